// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

This bridge lets a host reach a large bank of internal MAC configuration registers and a slower management bank through three directly mapped 32-bit words: a command word, a data word and a status word. To write an internal register, the host first loads the data word. It then writes the command word with the write flag set and the register number. To read one, the host writes the command word with the flag clear, polls the status word until the bridge is ready, and then fetches the data word.

Only one indirect operation can be outstanding. How long it runs depends on its target. Configuration registers and unmapped numbers finish after a short fixed latency. Management-class registers finish after a much longer, parameterised delay. A command that arrives while an operation is running is dropped and leaves a sticky flag that the host can see. Both register banks are modelled inside the block.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the status word reads 1 (ready set, overrun clear), the command and data words read zero, and every internal register reads zero.
- R2: Window offsets are 0 = command, 1 = data, 2 = status. A command write with bit 15 set writes the data word, as captured when the command was accepted, into the register numbered by bits 9:0. A later data-word write during the operation does not change the value stored.
- R3: A command write with bit 15 clear loads the data word with the addressed register's contents once the operation completes.
- R4: Status bit 0 (ready) goes low on the cycle after a command is accepted. For configuration numbers (0 to 15) and unmapped numbers it stays low for exactly 2 cycles.
- R5: For management numbers (0x100 to 0x10F) ready stays low for exactly 64 cycles.
- R6: A command write while ready is low is ignored: the in-flight target and its result are unchanged. It also sets status bit 1 (overrun).
- R7: Overrun stays set until the host writes the status word with bit 1 set. A status write with bit 1 clear leaves it set.
- R8: When a read completes in the same cycle that the host writes the data word, the read result is what the data word holds afterwards.
- R9: Register numbers outside both banks read as zero, and writes to them have no effect.
- R10: The two banks are separate: configuration register n and management register 0x100+n hold independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Write strobe for the window word at host_addr |
| host_addr | input | 2 | Window word select: 0 command, 1 data, 2 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Contents of the selected window word (combinational) |

## Verification
The completion of an indirect read and a host write of the data word can land on the same clock edge, and both try to update the data word. The bench provokes this by accepting a configuration read and then issuing a data-word write exactly two edges later, on the completion edge. The data word must then hold the register contents and not the host value. A second collision, a new command arriving while the bridge is busy, is provoked during a long management operation. It is judged by the overrun flag and by the original target still receiving its value.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int NUM_W    = 10;
    localparam int WE_BIT   = 15;
    localparam int STAT_RDY = 0;
    localparam int STAT_OVR = 1;

    typedef enum logic [1:0] {
        WIN_CTRL = 2'd0,
        WIN_DATA = 2'd1,
        WIN_STAT = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef struct packed {
        logic             we;
        logic [NUM_W-1:0] num;
    } cmd_t;

endpackage

// File: rtl/ibr_regbank.sv
module ibr_regbank #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = mem_q[k];
        end
    end

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq #(
    parameter int CFG_LAT  = 2,
    parameter int MGMT_LAT = 64,
    localparam int MAX_LAT = (MGMT_LAT > CFG_LAT) ? MGMT_LAT : CFG_LAT,
    localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic slow,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = slow ? CNT_W'(MGMT_LAT - 1) : CNT_W'(CFG_LAT - 1);
            end
        end else if (s_q.cnt == '0) begin
            s_d.busy = 1'b0;
            done     = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !s_q.busy) |=> s_q.busy); // R4
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt < CNT_W'(MAX_LAT))); // R5
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) - 1'b1)); // R5

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
    parameter int DATA_W    = 32,
    parameter int NUM_CFG   = 16,
    parameter int NUM_MGMT  = 16,
    parameter int MGMT_BASE = 256,
    parameter int CFG_LAT   = 2,
    parameter int MGMT_LAT  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    import ibr_pkg::*;

    localparam int CIW = (NUM_CFG  > 1) ? $clog2(NUM_CFG)  : 1;
    localparam int MIW = (NUM_MGMT > 1) ? $clog2(NUM_MGMT) : 1;

    typedef struct packed {
        cmd_t              cmd;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] pend;
        logic              overrun;
    } br_t;

    br_t st_d, st_q;

    logic              busy, done, accept, cmd_wr, stat_clr, data_wr;
    logic              new_slow, tgt_cfg, tgt_mgmt;
    logic              cfg_wr, mgmt_wr;
    logic [NUM_W-1:0]  new_num;
    logic [DATA_W-1:0] cfg_rd, mgmt_rd, rd_result;
    logic [CIW-1:0]    cfg_idx;
    logic [MIW-1:0]    mgmt_idx;

    function automatic logic in_mgmt(input logic [NUM_W-1:0] n);
        return (32'(n) >= MGMT_BASE) && (32'(n) < MGMT_BASE + NUM_MGMT);
    endfunction

    assign cmd_wr   = host_we && (host_addr == WIN_CTRL);
    assign data_wr  = host_we && (host_addr == WIN_DATA);
    assign stat_clr = host_we && (host_addr == WIN_STAT) && host_wdata[STAT_OVR];
    assign accept   = cmd_wr && !busy;
    assign new_num  = host_wdata[NUM_W-1:0];
    assign new_slow = in_mgmt(new_num);

    assign tgt_cfg  = 32'(st_q.cmd.num) < NUM_CFG;
    assign tgt_mgmt = in_mgmt(st_q.cmd.num);
    assign cfg_idx  = CIW'(st_q.cmd.num);
    assign mgmt_idx = MIW'(st_q.cmd.num - NUM_W'(MGMT_BASE));
    assign cfg_wr   = done && st_q.cmd.we && tgt_cfg;
    assign mgmt_wr  = done && st_q.cmd.we && tgt_mgmt;
    assign rd_result = tgt_cfg ? cfg_rd : (tgt_mgmt ? mgmt_rd : '0);

    ibr_seq #(.CFG_LAT(CFG_LAT), .MGMT_LAT(MGMT_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .slow(new_slow),
        .busy(busy), .done(done)
    );

    ibr_regbank #(.NREGS(NUM_CFG), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_idx(cfg_idx),
        .wr_data(st_q.pend), .rd_idx(cfg_idx), .rd_data(cfg_rd)
    );

    ibr_regbank #(.NREGS(NUM_MGMT), .DATA_W(DATA_W)) u_mgmt (
        .clk(clk), .rst_n(rst_n), .wr_en(mgmt_wr), .wr_idx(mgmt_idx),
        .wr_data(st_q.pend), .rd_idx(mgmt_idx), .rd_data(mgmt_rd)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.cmd.we  = host_wdata[WE_BIT];
            st_d.cmd.num = new_num;
            st_d.pend    = st_q.data;
        end
        if (cmd_wr && busy) st_d.overrun = 1'b1;
        if (stat_clr)       st_d.overrun = 1'b0;
        if (data_wr)        st_d.data    = host_wdata;
        if (done && !st_q.cmd.we) st_d.data = rd_result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            WIN_CTRL: begin
                host_rdata[WE_BIT]    = st_q.cmd.we;
                host_rdata[NUM_W-1:0] = st_q.cmd.num;
            end
            WIN_DATA: host_rdata = st_q.data;
            WIN_STAT: begin
                host_rdata[STAT_RDY] = !busy;
                host_rdata[STAT_OVR] = st_q.overrun;
            end
            default: host_rdata = '0;
        endcase
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R4
    AST_OVERRUN_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> st_q.overrun); // R6
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(st_q.cmd)); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.overrun && !stat_clr) |=> st_q.overrun); // R7
    AST_BANK_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || mgmt_wr) |-> busy); // R2
    AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.cmd.we) |=> (st_q.data == $past(rd_result))); // R8

endmodule

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [1:0] A_CMD = 2'd0, A_DATA = 2'd1, A_STAT = 2'd2;
    localparam logic [31:0] WFLAG = 32'h0000_8000;

    // {is_write, register number, data or expected read value}
    localparam logic [42:0] VEC [10] = '{
        {1'b1, 10'h003, 32'hA5A5_0001},
        {1'b1, 10'h101, 32'hDEAD_BEEF},
        {1'b1, 10'h00F, 32'h1234_5678},
        {1'b0, 10'h003, 32'hA5A5_0001},
        {1'b0, 10'h101, 32'hDEAD_BEEF},
        {1'b0, 10'h001, 32'h0000_0000},
        {1'b0, 10'h00F, 32'h1234_5678},
        {1'b1, 10'h3FF, 32'hFFFF_FFFF},
        {1'b0, 10'h3FF, 32'h0000_0000},
        {1'b0, 10'h100, 32'h0000_0000}
    };

    ind_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_ready(output int n);
        logic [31:0] s;
        n = 0;
        forever begin
            bus_read(A_STAT, s);
            if (s[0] || n > 1000) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic ind_read(input logic [9:0] num, output logic [31:0] d);
        int n;
        bus_write(A_CMD, {22'd0, num});
        wait_ready(n);
        bus_read(A_DATA, d);
    endtask

    task automatic ind_write(input logic [9:0] num, input logic [31:0] d);
        int n;
        bus_write(A_DATA, d);
        bus_write(A_CMD, WFLAG | {22'd0, num});
        wait_ready(n);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_STAT, v); check("R1 status", v, 32'h1);
        bus_read(A_CMD, v);  check("R1 command", v, 32'h0);
        bus_read(A_DATA, v); check("R1 data", v, 32'h0);
        ind_read(10'h005, v); check("R1 cfg reg", v, 32'h0);
        ind_read(10'h105, v); check("R1 mgmt reg", v, 32'h0);

        // table walk: R2 R3 R9 R10
        foreach (VEC[i]) begin
            if (VEC[i][42]) begin
                ind_write(VEC[i][41:32], VEC[i][31:0]);
            end else begin
                ind_read(VEC[i][41:32], v);
                check($sformatf("R3/R9/R10 vec %0d", i), v, VEC[i][31:0]);
            end
        end

        // R4 configuration latency
        bus_write(A_CMD, 32'h0000_0003);
        wait_ready(n);
        check("R4 cfg ready-low cycles", n, 2);
        // R9 unmapped latency equals cfg
        bus_write(A_CMD, 32'h0000_0200);
        wait_ready(n);
        check("R9 unmapped ready-low cycles", n, 2);

        // R5 management latency
        bus_write(A_CMD, 32'h0000_0101);
        wait_ready(n);
        check("R5 mgmt ready-low cycles", n, 64);

        // R2 write data captured at accept; R6 collision during busy
        bus_write(A_DATA, 32'h0BAD_F00D);
        bus_write(A_CMD, WFLAG | 32'h107);
        bus_write(A_DATA, 32'h7777_7777);
        bus_write(A_CMD, WFLAG | 32'h002);
        bus_read(A_STAT, v); check("R6 overrun set while busy", v, 32'h2);
        bus_read(A_CMD, v);  check("R6 target kept", v, WFLAG | 32'h107);
        wait_ready(n);
        ind_read(10'h107, v); check("R2 captured write data", v, 32'h0BAD_F00D);
        ind_read(10'h002, v); check("R6 dropped write had no effect", v, 32'h0);

        // R7 sticky overrun and clear
        bus_read(A_STAT, v); check("R7 overrun sticky", v, 32'h3);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, v); check("R7 clear with bit1 low", v, 32'h3);
        bus_write(A_STAT, 32'h2);
        bus_read(A_STAT, v); check("R7 cleared", v, 32'h1);

        // R8 read completion collides with host data write
        bus_write(A_CMD, 32'h0000_0003);
        bus_write(A_DATA, 32'h5555_AAAA);
        wait_ready(n);
        bus_read(A_DATA, v); check("R8 read result wins", v, 32'hA5A5_0001);
        // host data write after completion does land
        bus_write(A_DATA, 32'h5555_AAAA);
        bus_read(A_DATA, v); check("R8 later data write", v, 32'h5555_AAAA);

        // R10 bank separation after more traffic
        ind_write(10'h00E, 32'h1111_2222);
        ind_read(10'h10E, v); check("R10 mgmt untouched", v, 32'h0);
        ind_read(10'h00E, v); check("R10 cfg value", v, 32'h1111_2222);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule